// File: doc/BRIEF.md
# Banked PCS Management Register Window

This block presents the management registers of a serial PCS as an 8 KiB window on a 16-bit slave bus. The bus carries a byte address, separate read and write strobes, write data and registered read data. One fixed location in the window holds a bank selector. Every other location reaches a register in whichever of four banks the selector currently names. The four banks are control/ID, MII, timing-sync and vendor MII. Each bank is a set of 16-bit registers with fixed power-on values.

Software first writes a bank code to the selector and then reads or writes registers within that bank by offset. Bank registers come up at their defaults after the hardware reset. Software can restore them all at once with a self-clearing soft reset, which it triggers by setting the top bit of the MII control register. The selector keeps its value through a soft reset. The hardware reset clears it to 0, which is not a valid bank code.

Top module: `pcs_bank_window`

## Requirements
- R1: After the hardware reset the read data port is 0 and the selector reads 0x0000.
- R2: Byte offset 0x1FE always accesses the 16-bit selector. It stores and returns any value, and writes there change no bank register.
- R3: Selector code 0x1E00 maps the window to the control/ID bank, 0x1F00 to the MII bank, 0x1F07 to the timing-sync bank and 0x1F80 to the vendor bank. At most one bank is mapped at any time.
- R4: Any offset other than 0x1FE addresses register number offset/2 (address bits 12:1) of the mapped bank. A write followed by a read returns the written value, and the same index in different banks holds independent values.
- R5: A read at an index at or beyond the bank's register count (control 24, MII 32, timing 24, vendor 256) returns 0, and a write there changes no register.
- R6: While the selector holds any value other than the four codes, a read at a non-selector offset returns 0 and a write is discarded.
- R7: Read data updates only at the clock edge that samples the read strobe, so it is valid in the following cycle. It holds its value while no read is strobed, including across writes.
- R8: A write to MII bank index 0 with bit 15 set reloads every register of all four banks with its default. The reset values win over the write itself, so MII control reads back 0x1140 with bit 15 clear. The selector is unchanged.
- R9: A write to MII bank index 0 with bit 15 clear is stored like any other register write.
- R10: Defaults, as index:value. Control: 4:0x699E, 8:0x8000. MII: 0:0x1140, 1:0x0109, 2:0x699E, 3:0xCED0, 4:0x0020, 15:0xC000. Timing: 8:0x0003, 9:0x0038, 11:0x0038, 13:0x0058, 15:0x0048. Vendor: 0:0x2400, 2:0x000A, 6:0x899C, 16:0x0010, 56:0x000A, 58:0x007F, 61:0x0001, 88:0x0100, 89:0x1100, 93:0x000E, 120:0x0100, 121:0x0032, 136:0x0001, 152:0x0019. Every other register defaults to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_addr | input | 13 | Byte address within the window; bit 0 is ignored |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data, valid the cycle after the read strobe |

## Verification
The hardest condition to reach from the ports is a soft reset whose effect has to be observed in banks that are not mapped when it fires. The stimulus first writes marker values into the same index of all four banks. It then triggers the reset from the MII bank and walks the selector through each bank, confirming every marker has returned to its default while the selector kept its code. The other difficult condition is an invalid selector code. Here the bench issues a write with the bad code, then restores a valid code and reads the target register to show that the discarded write left no trace.

// File: rtl/pcs_win_pkg.sv
package pcs_win_pkg;

  localparam int unsigned WORD_W    = 16;
  localparam int unsigned NUM_BANKS = 4;

  typedef enum logic [1:0] {
    BK_CTRL = 2'd0,
    BK_MII  = 2'd1,
    BK_TIM  = 2'd2,
    BK_VEND = 2'd3
  } bank_e;

  // Selector code that maps each bank into the window.
  function automatic logic [WORD_W-1:0] bank_code(bank_e b);
    logic [WORD_W-1:0] c;
    unique case (b)
      BK_CTRL: c = 16'h1E00;
      BK_MII:  c = 16'h1F00;
      BK_TIM:  c = 16'h1F07;
      default: c = 16'h1F80;
    endcase
    return c;
  endfunction

  // Power-on and soft-reset value of register i of bank b.
  function automatic logic [WORD_W-1:0] reg_default(bank_e b, int unsigned i);
    logic [WORD_W-1:0] v;
    v = '0;
    unique case (b)
      BK_CTRL: begin
        case (i)
          4:       v = 16'h699E;
          8:       v = 16'h8000;
          default: v = '0;
        endcase
      end
      BK_MII: begin
        case (i)
          0:       v = 16'h1140;
          1:       v = 16'h0109;
          2:       v = 16'h699E;
          3:       v = 16'hCED0;
          4:       v = 16'h0020;
          15:      v = 16'hC000;
          default: v = '0;
        endcase
      end
      BK_TIM: begin
        case (i)
          8:       v = 16'h0003;
          9:       v = 16'h0038;
          11:      v = 16'h0038;
          13:      v = 16'h0058;
          15:      v = 16'h0048;
          default: v = '0;
        endcase
      end
      default: begin
        case (i)
          0:       v = 16'h2400;
          2:       v = 16'h000A;
          6:       v = 16'h899C;
          16:      v = 16'h0010;
          56:      v = 16'h000A;
          58:      v = 16'h007F;
          61:      v = 16'h0001;
          88:      v = 16'h0100;
          89:      v = 16'h1100;
          93:      v = 16'h000E;
          120:     v = 16'h0100;
          121:     v = 16'h0032;
          136:     v = 16'h0001;
          152:     v = 16'h0019;
          default: v = '0;
        endcase
      end
    endcase
    return v;
  endfunction

endpackage

// File: rtl/pcs_win_rst_sync.sv
module pcs_win_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] stage_q;
  logic [STAGES-1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
    end else begin
      stage_q <= stage_d;
    end
  end

  assign rst_sync_n = stage_q[STAGES-1];

endmodule

// File: rtl/pcs_win_decode.sv
module pcs_win_decode
  import pcs_win_pkg::*;
#(
  parameter int unsigned    ADDR_W     = 13,
  parameter logic [12:0]    SEL_OFFSET = 13'h1FE,
  localparam int unsigned   IDX_W      = ADDR_W - 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [WORD_W-1:0]    sel_code,
  output logic                 sel_hit,
  output logic [NUM_BANKS-1:0] bank_hit,
  output logic [IDX_W-1:0]     idx
);

  localparam logic [IDX_W-1:0] SEL_IDX = IDX_W'(SEL_OFFSET >> 1);

  logic unused_lsb;
  assign unused_lsb = addr[0];

  assign idx     = addr[ADDR_W-1:1];
  assign sel_hit = (idx == SEL_IDX);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_hit
    assign bank_hit[b] = !sel_hit && (sel_code == bank_code(bank_e'(b)));
  end

  AST_ONE_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_hit)); // R3

endmodule

// File: rtl/pcs_win_bank.sv
module pcs_win_bank
  import pcs_win_pkg::*;
#(
  parameter bank_e       BANK  = BK_CTRL,
  parameter int unsigned COUNT = 24,
  parameter int unsigned IDX_W = 12,
  localparam int unsigned SEL_W = (COUNT > 1) ? $clog2(COUNT) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  idx,
  input  logic [WORD_W-1:0] wdata,
  input  logic              soft_rst,
  output logic [WORD_W-1:0] rd_word
);

  logic [WORD_W-1:0] regs_q [COUNT];
  logic [WORD_W-1:0] regs_d [COUNT];
  logic [COUNT-1:0]  reg_en;
  logic              in_range;

  assign in_range = (32'(idx) < COUNT);

  // Next-state: soft reset loads defaults and overrides any write.
  always_comb begin
    for (int unsigned i = 0; i < COUNT; i++) begin
      reg_en[i] = soft_rst | (wr_en & in_range & (32'(idx) == i));
      regs_d[i] = soft_rst ? reg_default(BANK, i) : wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int unsigned i = 0; i < COUNT; i++) begin
        regs_q[i] <= reg_default(BANK, i);
      end
    end else begin
      for (int unsigned i = 0; i < COUNT; i++) begin
        if (reg_en[i]) begin
          regs_q[i] <= regs_d[i];
        end
      end
    end
  end

  always_comb begin
    rd_word = '0;
    if (in_range) begin
      rd_word = regs_q[idx[SEL_W-1:0]];
    end
  end

  AST_SOFT_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (regs_q[0] == reg_default(BANK, 0))); // R8

  AST_OOR_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !soft_rst && (32'(idx) >= COUNT)) |=> $stable(regs_q[0])); // R5

endmodule

// File: rtl/pcs_bank_window.sv
module pcs_bank_window
  import pcs_win_pkg::*;
#(
  parameter int unsigned ADDR_W     = 13,
  parameter int unsigned CTRL_REGS  = 24,
  parameter int unsigned MII_REGS   = 32,
  parameter int unsigned TIM_REGS   = 24,
  parameter int unsigned VEND_REGS  = 256,
  parameter logic [12:0] SEL_OFFSET = 13'h1FE,
  parameter int unsigned SRST_BIT   = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       bus_rdata
);

  localparam int unsigned IDX_W    = ADDR_W - 1;
  localparam int unsigned MII_SLOT = int'(BK_MII);

  logic                 rst_core_n;
  logic                 sel_hit;
  logic [NUM_BANKS-1:0] bank_hit;
  logic [IDX_W-1:0]     idx;
  logic [WORD_W-1:0]    sel_q;
  logic [WORD_W-1:0]    sel_d;
  logic                 sel_en;
  logic                 soft_rst;
  logic [WORD_W-1:0]    bank_word [NUM_BANKS];
  logic [WORD_W-1:0]    rdata_d;
  logic [WORD_W-1:0]    rdata_q;

  pcs_win_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  pcs_win_decode #(.ADDR_W(ADDR_W), .SEL_OFFSET(SEL_OFFSET)) u_decode (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .addr     (bus_addr),
    .sel_code (sel_q),
    .sel_hit  (sel_hit),
    .bank_hit (bank_hit),
    .idx      (idx)
  );

  // Bank selector: untouched by the soft reset.
  always_comb begin
    sel_en = bus_wr & sel_hit;
    sel_d  = bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      sel_q <= '0;
    end else if (sel_en) begin
      sel_q <= sel_d;
    end
  end

  assign soft_rst = bus_wr & bank_hit[MII_SLOT] & (idx == '0) & bus_wdata[SRST_BIT];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam int unsigned CNT = (b == 0) ? CTRL_REGS :
                                  (b == 1) ? MII_REGS  :
                                  (b == 2) ? TIM_REGS  : VEND_REGS;
    pcs_win_bank #(
      .BANK  (bank_e'(b)),
      .COUNT (CNT),
      .IDX_W (IDX_W)
    ) u_bank (
      .clk      (clk),
      .rst_n    (rst_core_n),
      .wr_en    (bus_wr & bank_hit[b]),
      .idx      (idx),
      .wdata    (bus_wdata),
      .soft_rst (soft_rst),
      .rd_word  (bank_word[b])
    );
  end

  always_comb begin
    rdata_d = '0;
    if (sel_hit) begin
      rdata_d = sel_q;
    end else begin
      for (int b = 0; b < NUM_BANKS; b++) begin
        if (bank_hit[b]) begin
          rdata_d = rdata_d | bank_word[b];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      rdata_q <= '0;
    end else if (bus_rd) begin
      rdata_q <= rdata_d;
    end
  end

  assign bus_rdata = rdata_q;

  AST_SEL_KEEP: assert property (@(posedge clk) disable iff (!rst_core_n)
    !(bus_wr && sel_hit) |=> $stable(sel_q)); // R2

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_core_n)
    !bus_rd |=> $stable(bus_rdata)); // R7

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_core_n)
    (bus_rd && !sel_hit && (bank_hit == '0)) |=> (bus_rdata == '0)); // R6

  AST_SOFT_KEEPS_SEL: assert property (@(posedge clk) disable iff (!rst_core_n)
    soft_rst |=> $stable(sel_q)); // R8

endmodule

// File: tb/pcs_bank_window_bench.sv
module pcs_bank_window_bench;

  logic        clk;
  logic        rst_n;
  logic [12:0] bus_addr;
  logic        bus_wr;
  logic        bus_rd;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;

  int n_checks;
  int n_fail;
  bit done;

  logic [15:0] exp_q [$];
  string       tag_q [$];

  localparam logic [12:0] SEL  = 13'h1FE;
  localparam logic [15:0] CTRL = 16'h1E00;
  localparam logic [15:0] MII  = 16'h1F00;
  localparam logic [15:0] TIM  = 16'h1F07;
  localparam logic [15:0] VEND = 16'h1F80;

  pcs_bank_window u_pcs_bank_window (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [12:0] a, logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  // Driver: issue a read and push the expected value to the scoreboard.
  task automatic rd(logic [12:0] a, logic [15:0] exp, string tag);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  // Register index to byte offset.
  function automatic logic [12:0] ix(int i);
    return 13'(i * 2);
  endfunction

  // Monitor: compare read data in the cycle after the strobe.
  initial begin
    forever begin
      @(posedge clk);
      if (bus_rd) begin
        @(negedge clk);
        if (exp_q.size() > 0) begin
          check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
        end
      end
    end
  end

  task automatic hw_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] held;
    n_checks = 0; n_fail = 0; done = 1'b0;
    rst_n = 1'b0; bus_addr = '0; bus_wr = 1'b0; bus_rd = 1'b0; bus_wdata = '0;
    hw_reset();

    // R1: reset state
    check("R1", bus_rdata, 16'h0000);
    rd(SEL, 16'h0000, "R1");
    // R6: selector 0 is not a bank
    rd(ix(0), 16'h0000, "R6");

    // R2 / R3: program and read back selector
    wr(SEL, MII);
    rd(SEL, MII, "R2");
    // R10: MII defaults
    rd(ix(0), 16'h1140, "R10");
    rd(ix(1), 16'h0109, "R10");
    rd(ix(2), 16'h699E, "R10");
    rd(ix(3), 16'hCED0, "R10");
    rd(ix(4), 16'h0020, "R10");
    rd(ix(15), 16'hC000, "R10");
    rd(ix(5), 16'h0000, "R10");

    wr(SEL, CTRL);
    rd(ix(4), 16'h699E, "R3");
    rd(ix(8), 16'h8000, "R10");
    rd(ix(0), 16'h0000, "R10");

    wr(SEL, TIM);
    rd(ix(8), 16'h0003, "R3");
    rd(ix(9), 16'h0038, "R10");
    rd(ix(11), 16'h0038, "R10");
    rd(ix(13), 16'h0058, "R10");
    rd(ix(15), 16'h0048, "R10");

    wr(SEL, VEND);
    rd(ix(0), 16'h2400, "R3");
    rd(ix(136), 16'h0001, "R10");
    rd(ix(152), 16'h0019, "R10");
    rd(ix(93), 16'h000E, "R10");

    // R4: same index, four banks, independent values
    wr(ix(3), 16'hA5A5);
    wr(ix(200), 16'h7E57);
    wr(SEL, CTRL);  wr(ix(3), 16'h1234);
    wr(SEL, TIM);   wr(ix(3), 16'h5678);
    wr(SEL, MII);   wr(ix(3), 16'h9ABC);
    rd(ix(3), 16'h9ABC, "R4");
    wr(SEL, CTRL);  rd(ix(3), 16'h1234, "R4");
    wr(SEL, TIM);   rd(ix(3), 16'h5678, "R4");
    wr(SEL, VEND);  rd(ix(3), 16'hA5A5, "R4");
    rd(ix(200), 16'h7E57, "R4");

    // R5: beyond bank count
    wr(SEL, CTRL);
    wr(ix(24), 16'hFFFF);
    rd(ix(24), 16'h0000, "R5");
    rd(ix(23), 16'h0000, "R5");
    rd(ix(3), 16'h1234, "R5");
    wr(SEL, MII);
    rd(ix(40), 16'h0000, "R5");

    // R6: unrecognised selector
    wr(SEL, 16'h1F01);
    wr(ix(3), 16'hDEAD);
    rd(ix(3), 16'h0000, "R6");
    wr(SEL, MII);
    rd(ix(3), 16'h9ABC, "R6");

    // R9: control write without the reset bit
    wr(ix(0), 16'h0140);
    rd(ix(0), 16'h0140, "R9");

    // R8: soft reset reloads all banks, selector kept
    wr(ix(0), 16'h8000);
    rd(ix(0), 16'h1140, "R8");
    rd(SEL, MII, "R8");
    rd(ix(3), 16'hCED0, "R8");
    wr(SEL, CTRL);  rd(ix(3), 16'h0000, "R8");
    wr(SEL, TIM);   rd(ix(3), 16'h0000, "R8");
    wr(SEL, VEND);  rd(ix(3), 16'h0000, "R8");
    rd(ix(200), 16'h0000, "R8");
    rd(ix(0), 16'h2400, "R8");

    // R7: read data holds without a read strobe, even across writes
    repeat (2) @(negedge clk);
    held = bus_rdata;
    check("R7", held, 16'h2400);
    wr(ix(0), 16'h0F0F);
    repeat (3) @(negedge clk);
    check("R7", bus_rdata, held);
    rd(ix(0), 16'h0F0F, "R7");

    // R2: selector takes any value; writing it leaves banks alone
    wr(SEL, 16'hBEEF);
    rd(SEL, 16'hBEEF, "R2");
    wr(SEL, VEND);
    rd(ix(0), 16'h0F0F, "R2");

    // R1: hardware reset mid-run clears selector, restores banks
    hw_reset();
    check("R1", bus_rdata, 16'h0000);
    rd(SEL, 16'h0000, "R1");
    wr(SEL, VEND);
    rd(ix(0), 16'h2400, "R1");

    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule